// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Slave

This block is a slave on a two-wire serial bus, placed in front of a byte-wide memory of 4096 locations. Synchronized copies of the clock and data lines are taken in, and the data line is pulled low through a single open-drain enable. A master selects the device with a control byte. That byte holds a fixed type code, three select bits that are compared against strap inputs, and a direction bit. The master then writes a two-byte word address without writing any data, issues a repeated start, and reads bytes back for as long as it keeps acknowledging.

A 12-bit read pointer survives from one transaction to the next. It advances after every byte sent and wraps from the last location back to the first, so a read that starts with no address phase continues from wherever the pointer stands. With eight devices on one bus, each strapped to a different select value, the three select bits act as the upper system address bits and give one contiguous space. A synchronous write port lets the surrounding logic preload the memory contents.

Top module: `i2cmem_slave`

## Requirements
- R1: After reset the slave does not pull the data line low (`sdaOe` = 0), and the read pointer is 0.
- R2: The slave acknowledges a control byte only when its bits 7:4 equal 4'b1010 and its bits 3:1 equal `devSel`. On any other value it does not acknowledge and leaves the line released until the next START, including while later bytes are clocked.
- R3: For a random read, the slave acknowledges the write control byte, the address high byte, the address low byte and the read control byte. It then returns the byte stored at the loaded address.
- R4: Only the low four bits of the address high byte form pointer bits 11:8; the upper four bits are ignored.
- R5: Each master acknowledge after a data byte makes the slave send the byte at the next address. Data goes out MSB first.
- R6: A master acknowledge of the byte from address 0xFFF makes the next byte come from address 0x000.
- R7: After a master NACK the slave releases the line and sends no further data, even if the clock keeps running.
- R8: The pointer advances by one after each byte sent and keeps its value across transactions, so a read control byte with no address phase returns data from the current pointer.
- R9: A START in any state, including in the middle of a byte, restarts the byte framing. A complete transaction that follows it is served normally.
- R10: The slave changes the data line only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| devSel | input | 3 | Strap value compared with the control byte select bits |
| sdaOe | output | 1 | 1 pulls the data line low |
| memWe | input | 1 | Preload write strobe |
| memAddr | input | ADDR_W | Preload address |
| memWdata | input | 8 | Preload data |

## Verification
The bench builds the block with its default values: a 12-bit pointer over 4096 locations, a two-stage input synchronizer and type code 4'b1010. It also straps the select inputs to 3'b101. At full pointer width, a real address with non-zero upper bits reaches the 0xFFF-to-0x000 wrap, and the bench can prove the ignored nibble with the address 0xF2/0x00. The non-trivial strap value lets both a wrong select field and a wrong type code be rejected while the matching value is accepted.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CTRL,
    S_ADDRH,
    S_ADDRL,
    S_TX
  } busState_e;

  // Strobes from the bus control to the datapath
  typedef struct packed {
    logic rxShift;
    logic hiLoad;
    logic ptrLoad;
    logic ptrInc;
    logic txLoad;
    logic txShift;
    logic oeAck;
    logic oeRelease;
  } dpStrobe_t;

endpackage

// File: rtl/i2cmem_dpath.sv
module i2cmem_dpath
  import i2cmem_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpStrobe_t         strobe,
  input  logic              memWe,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [BYTE_W-1:0] memWdata,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              sdaS,
  output logic [BYTE_W-1:0] rxByte,
  output logic              sdaOe
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - BYTE_W;

  logic sclS;
  logic sclPrev;
  logic sdaPrev;

  // Input synchronizers; depth picked by parameter
  generate
    if (SYNC_STAGES > 1) begin : g_multi
      logic [SYNC_STAGES-1:0] sclSync;
      logic [SYNC_STAGES-1:0] sdaSync;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
          sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
        end
      end
      assign sclS = sclSync[SYNC_STAGES-1];
      assign sdaS = sdaSync[SYNC_STAGES-1];
    end else begin : g_single
      logic sclQ;
      logic sdaQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclQ <= 1'b1;
          sdaQ <= 1'b1;
        end else begin
          sclQ <= sclIn;
          sdaQ <= sdaIn;
        end
      end
      assign sclS = sclQ;
      assign sdaS = sdaQ;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclRise  = sclS && !sclPrev;
  assign sclFall  = !sclS && sclPrev;
  assign startDet = sclS && sclPrev && sdaPrev && !sdaS;
  assign stopDet  = sclS && sclPrev && !sdaPrev && sdaS;

  // Receive shifter
  logic [BYTE_W-1:0] rxReg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxReg <= '0;
    else if (strobe.rxShift) rxReg <= {rxReg[BYTE_W-2:0], sdaS};
  end
  assign rxByte = rxReg;

  // Word address pointer
  logic [HI_W-1:0]   hiReg;
  logic [ADDR_W-1:0] ptr;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiReg <= '0;
      ptr   <= '0;
    end else begin
      if (strobe.hiLoad)  hiReg <= rxReg[HI_W-1:0];
      if (strobe.ptrLoad) ptr   <= {hiReg, rxReg};
      else if (strobe.ptrInc) ptr <= ptr + 1'b1;
    end
  end

  // Storage array with preload port
  logic [BYTE_W-1:0] mem [DEPTH];
  always_ff @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
  end

  logic [BYTE_W-1:0] rdByte;
  assign rdByte = mem[ptr];

  // Transmit shifter and open-drain enable
  logic [BYTE_W-1:0] txReg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg <= '0;
      sdaOe <= 1'b0;
    end else begin
      if (strobe.txLoad) txReg <= rdByte;
      else if (strobe.txShift) txReg <= {txReg[BYTE_W-2:0], 1'b0};

      if (strobe.txLoad)         sdaOe <= ~rdByte[BYTE_W-1];
      else if (strobe.txShift)   sdaOe <= ~txReg[BYTE_W-2];
      else if (strobe.oeAck)     sdaOe <= 1'b1;
      else if (strobe.oeRelease) sdaOe <= 1'b0;
    end
  end

endmodule

// File: rtl/i2cmem_ctrl.sv
module i2cmem_ctrl
  import i2cmem_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        devSel,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              sdaS,
  input  logic [BYTE_W-1:0] rxByte,
  output dpStrobe_t         strobe,
  output busState_e         state,
  output logic [CNT_W-1:0]  bitCnt
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W + 1);

  logic rwBit;
  logic isRx;
  logic busEvt;
  logic selMatch;
  logic atLast;
  logic atAck;

  assign isRx     = (state == S_CTRL) || (state == S_ADDRH) || (state == S_ADDRL);
  assign busEvt   = startDet || stopDet;
  assign selMatch = (rxByte[7:4] == DEV_TYPE) && (rxByte[3:1] == devSel);
  assign atLast   = (bitCnt == LAST_BIT);
  assign atAck    = (bitCnt == ACK_SLOT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      bitCnt <= '0;
      rwBit  <= 1'b0;
    end else if (startDet) begin
      state  <= S_CTRL;
      bitCnt <= '0;
    end else if (stopDet) begin
      state  <= S_IDLE;
      bitCnt <= '0;
    end else begin
      unique case (state)
        S_IDLE: ;
        S_CTRL, S_ADDRH, S_ADDRL: begin
          if (sclRise) begin
            if (bitCnt < LAST_BIT) bitCnt <= bitCnt + 1'b1;
            else if (atLast)       bitCnt <= ACK_SLOT;
          end
          if (sclFall) begin
            if (atLast && state == S_CTRL) begin
              if (!selMatch) state <= S_IDLE;
              rwBit <= rxByte[0];
            end else if (atAck) begin
              bitCnt <= '0;
              unique case (state)
                S_CTRL:  state <= rwBit ? S_TX : S_ADDRH;
                S_ADDRH: state <= S_ADDRL;
                default: state <= S_IDLE;
              endcase
            end
          end
        end
        S_TX: begin
          if (sclRise) begin
            if (atLast) begin
              if (sdaS) state <= S_IDLE;
              else      bitCnt <= ACK_SLOT;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          if (sclFall && atAck) bitCnt <= '0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe = '0;
    if (busEvt) begin
      strobe.oeRelease = 1'b1;
    end else begin
      strobe.rxShift = isRx && sclRise && (bitCnt < LAST_BIT);
      strobe.oeAck   = isRx && sclFall && atLast && (state != S_CTRL || selMatch);
      strobe.oeRelease = (isRx && sclFall && atAck) ||
                         (state == S_TX && sclFall && atLast);
      strobe.hiLoad  = (state == S_ADDRH) && sclFall && atAck;
      strobe.ptrLoad = (state == S_ADDRL) && sclFall && atAck;
      strobe.ptrInc  = (state == S_TX) && sclRise && atLast;
      strobe.txLoad  = sclFall && atAck &&
                       ((state == S_CTRL && rwBit) || state == S_TX);
      strobe.txShift = (state == S_TX) && sclFall &&
                       (bitCnt != '0) && (bitCnt < LAST_BIT);
    end
  end

endmodule

// File: rtl/i2cmem_slave.sv
module i2cmem_slave
  import i2cmem_pkg::*;
#(
  parameter int         ADDR_W      = 12,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_TYPE    = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        devSel,
  output logic              sdaOe,
  input  logic              memWe,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memWdata
);

  dpStrobe_t         strobe;
  busState_e         ctlState;
  logic [CNT_W-1:0]  ctlBitCnt;
  logic              sclRise;
  logic              sclFall;
  logic              startDet;
  logic              stopDet;
  logic              sdaS;
  logic [BYTE_W-1:0] rxByte;

  i2cmem_ctrl #(.DEV_TYPE(DEV_TYPE)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .devSel   (devSel),
    .startDet (startDet),
    .stopDet  (stopDet),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .sdaS     (sdaS),
    .rxByte   (rxByte),
    .strobe   (strobe),
    .state    (ctlState),
    .bitCnt   (ctlBitCnt)
  );

  i2cmem_dpath #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .strobe   (strobe),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startDet (startDet),
    .stopDet  (stopDet),
    .sdaS     (sdaS),
    .rxByte   (rxByte),
    .sdaOe    (sdaOe)
  );

endmodule

// File: rtl/i2cmem_slave_chk.sv
module i2cmem_slave_chk
  import i2cmem_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaOe,
  input logic              startDet,
  input busState_e         state,
  input logic [CNT_W-1:0]  bitCnt,
  input logic [ADDR_W-1:0] ptr
);

  // R10: line only moves while the bus clock is low
  a_r10_change_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !sclIn);

  // R7: an idle slave never pulls the line
  a_r7_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> !sdaOe);

  // R6: while sending, the pointer only steps by one (wrapping)
  a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == S_TX && ptr != $past(ptr)) |-> (ptr == $past(ptr) + 1'b1));

  // R9: a START always restarts the byte framing
  a_r9_start_restarts: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == S_CTRL && bitCnt == '0));

endmodule

bind i2cmem_slave i2cmem_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sclIn    (sclIn),
  .sdaOe    (sdaOe),
  .startDet (startDet),
  .state    (ctlState),
  .bitCnt   (ctlBitCnt),
  .ptr      (u_dp.ptr)
);

// File: tb/i2cmem_slave_tb.sv
`timescale 1ns/1ps
module i2cmem_slave_tb;

  localparam int ADDR_W = 12;
  localparam int HP     = 20;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] CW = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] CR = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic sdaOe;
  logic sdaLine;
  logic memWe = 1'b0;
  logic [ADDR_W-1:0] memAddr = '0;
  logic [7:0] memWdata = '0;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;
  assign sdaLine = mSda & ~sdaOe;

  i2cmem_slave #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .devSel(STRAP),
    .sdaOe(sdaOe), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic poke(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    memWe = 1'b1; memAddr = a; memWdata = d;
    waitClk(1);
    memWe = 1'b0;
  endtask

  task automatic startCond();
    mSda = 1'b1; waitClk(HP);
    mScl = 1'b1; waitClk(HP);
    mSda = 1'b0; waitClk(HP);
    mScl = 1'b0;
  endtask

  task automatic stopCond();
    mSda = 1'b0; waitClk(HP);
    mScl = 1'b1; waitClk(HP);
    mSda = 1'b1; waitClk(HP);
  endtask

  task automatic clockBit(input logic b);
    mSda = b; waitClk(HP);
    mScl = 1'b1; waitClk(HP);
    mScl = 1'b0;
  endtask

  task automatic writeByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) clockBit(b[i]);
    mSda = 1'b1; waitClk(HP);
    mScl = 1'b1; waitClk(HP / 2);
    ack = !sdaLine;
    waitClk(HP / 2);
    mScl = 1'b0;
  endtask

  task automatic readByte(input bit masterAck, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      mSda = 1'b1; waitClk(HP);
      mScl = 1'b1; waitClk(HP / 2);
      b[i] = sdaLine;
      waitClk(HP / 2);
      mScl = 1'b0;
    end
    clockBit(!masterAck);
    mSda = 1'b1;
  endtask

  task automatic setPointer(input logic [7:0] hi, input logic [7:0] lo);
    bit a;
    startCond();
    writeByte(CW, a);  check(a, "R3 ack write control", a, 1);
    writeByte(hi, a);  check(a, "R3 ack address high", a, 1);
    writeByte(lo, a);  check(a, "R3 ack address low", a, 1);
  endtask

  task automatic readPhase();
    bit a;
    startCond();
    writeByte(CR, a);  check(a, "R2 ack read control", a, 1);
  endtask

  task automatic testReset();
    check(sdaOe == 1'b0, "R1 released after reset", sdaOe, 0);
  endtask

  task automatic testCurrentAfterReset();
    logic [7:0] d;
    readPhase(); readByte(1'b0, d); stopCond();
    check(d == 8'h33, "R1 R8 pointer starts at zero", d, 8'h33);
    readPhase(); readByte(1'b0, d); stopCond();
    check(d == 8'h44, "R8 pointer persists", d, 8'h44);
  endtask

  task automatic testRandom();
    logic [7:0] d;
    setPointer(8'h01, 8'h23); readPhase(); readByte(1'b0, d); stopCond();
    check(d == 8'hA5, "R3 random read data", d, 8'hA5);
  endtask

  task automatic testSequential();
    logic [7:0] d;
    setPointer(8'h01, 8'h24); readPhase();
    readByte(1'b1, d); check(d == 8'h5B, "R5 first byte", d, 8'h5B);
    readByte(1'b0, d); check(d == 8'h3C, "R5 next byte", d, 8'h3C);
    stopCond();
    readPhase(); readByte(1'b0, d); stopCond();
    check(d == 8'h66, "R8 current-address read", d, 8'h66);
  endtask

  task automatic testWrap();
    logic [7:0] d;
    setPointer(8'h0F, 8'hFE); readPhase();
    readByte(1'b1, d); check(d == 8'h11, "R6 byte at 0xFFE", d, 8'h11);
    readByte(1'b1, d); check(d == 8'h22, "R6 byte at 0xFFF", d, 8'h22);
    readByte(1'b0, d); check(d == 8'h33, "R6 wrapped to 0x000", d, 8'h33);
    stopCond();
  endtask

  task automatic testNack();
    logic [7:0] d;
    setPointer(8'h01, 8'h23); readPhase();
    readByte(1'b0, d); check(d == 8'hA5, "R7 data before NACK", d, 8'hA5);
    readByte(1'b0, d); check(d == 8'hFF, "R7 no data after NACK", d, 8'hFF);
    check(sdaOe == 1'b0, "R7 line released", sdaOe, 0);
    stopCond();
    readPhase(); readByte(1'b0, d); stopCond();
    check(d == 8'h5B, "R8 one step after NACKed byte", d, 8'h5B);
  endtask

  task automatic testHighNibble();
    logic [7:0] d;
    setPointer(8'hF2, 8'h00); readPhase(); readByte(1'b0, d); stopCond();
    check(d == 8'h77, "R4 upper address bits ignored", d, 8'h77);
  endtask

  task automatic testMismatch();
    bit a;
    logic [7:0] d;
    startCond();
    writeByte({4'b1010, 3'b000, 1'b0}, a);
    check(!a, "R2 wrong select not acked", a, 0);
    writeByte(8'h00, a);
    check(!a, "R2 ignored until START", a, 0);
    stopCond();
    startCond();
    writeByte({4'b1011, STRAP, 1'b1}, a);
    check(!a, "R2 wrong type not acked", a, 0);
    readByte(1'b0, d);
    check(d == 8'hFF, "R2 no data when unselected", d, 8'hFF);
    stopCond();
  endtask

  task automatic testRestart();
    bit a;
    logic [7:0] d;
    startCond();
    writeByte(CW, a);
    for (int i = 0; i < 4; i++) clockBit(1'b1);
    setPointer(8'h01, 8'h25); readPhase(); readByte(1'b0, d); stopCond();
    check(d == 8'h3C, "R9 restart mid byte", d, 8'h3C);
  endtask

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    testReset();
    poke(12'h000, 8'h33); poke(12'h001, 8'h44);
    poke(12'h123, 8'hA5); poke(12'h124, 8'h5B);
    poke(12'h125, 8'h3C); poke(12'h126, 8'h66);
    poke(12'hFFE, 8'h11); poke(12'hFFF, 8'h22);
    poke(12'h200, 8'h77);
    testCurrentAfterReset();
    testRandom();
    testSequential();
    testWrap();
    testNack();
    testHighNibble();
    testMismatch();
    testRestart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule